// File: doc/BRIEF.md
# Host message responder

This block is the controller-side end of a three-register host message channel. A host processor sees a data register, a control/status register and a flags register. To move one step through a transfer, the host does three things. It writes a byte into the data register and an opcode into the control register. It then sets the busy bit in the flags register. The responder samples the opcode and byte when busy is set. After a fixed number of cycles it drops busy and publishes a status code, a data value and new ready flags for that step.

A request is written byte by byte into a request buffer. The local logic can read that buffer through a side port once the request is complete. The local logic then loads a response into a response buffer and posts its length. The host reads the response back one byte per opcode. Each step is answered with a status code that the host checks before it takes the next step. A step that does not fit the current phase is rejected with a nonzero completion code, and the channel returns to idle.

Top module: `hostmsg_responder`

## Requirements
- R1: After reset, the status register reads 0xC0 and the data register reads 0x00. The flags register has bit 6 (transmit room) set and bits 7 (response byte ready), 3 (attention) and 0 (busy) clear.
- R2: A host write of 1 to flags bit 0 (address 2) sets busy for exactly BUSY_CYCLES cycles. Host writes to data (address 0) and control (address 1) are ignored while busy is set. Status and data change only in the cycle busy clears.
- R3: Opcode 0x40 is accepted in any phase and answered with status 0xC0 and data 0x00. Any transfer in progress is abandoned and the channel returns to idle.
- R4: Opcodes 0x41 (first byte, idle only), 0x42 (middle byte) and 0x43 (last byte) are answered with 0xC1, 0xC2 and 0xC3. They store the sampled data byte in order, starting at request index 0. The byte count and the bytes are readable on the local port.
- R5: After an accepted 0x43, the data register reads completion code 0x00 and req_done_o is high. Flags bit 6 is clear until the transaction ends.
- R6: Flags bit 6 is set in idle, and during a request while fewer than REQ_DEPTH bytes are stored. A 0x42 or 0x43 sent to a full buffer is rejected. Bits 6 and 7 are never set together.
- R7: Flags bit 7 is set after the local port posts a response following an accepted 0x43. It stays set throughout the read-back. An opcode 0x44 sent before the response is posted is rejected.
- R8: Opcode 0x44 presents response byte 0 with status 0xC4. Each 0x45 presents the next byte with status 0xC5, or 0xC6 when that byte is the last one. A 0x45 with no byte left is rejected.
- R9: Opcode 0x46, sent while the last byte is presented, is answered with status 0xC0 and data 0x00. Flags bit 7 then clears and bit 6 sets. A 0x46 sent before the last byte is rejected.
- R10: A rejected or unknown opcode is answered with status 0xC0 and data ERR_CODE (0x81 by default). The channel returns to idle, and a following 0x41 is accepted.
- R11: Flags bit 3 follows attn_i. The flags register never reads 0xFF, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_addr_i | input | 2 | Host register select: 0 data, 1 control/status, 2 flags |
| host_we_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data for the selected register |
| attn_i | input | 1 | Unsolicited message pending |
| req_raddr_i | input | $clog2(REQ_DEPTH) | Local read index into the request buffer |
| req_rdata_o | output | 8 | Request byte at req_raddr_i |
| req_len_o | output | $clog2(REQ_DEPTH+1) | Number of request bytes stored |
| req_done_o | output | 1 | Request complete, waiting for response |
| resp_we_i | input | 1 | Local response byte write |
| resp_waddr_i | input | $clog2(RESP_DEPTH) | Response byte index |
| resp_wdata_i | input | 8 | Response byte |
| resp_len_i | input | $clog2(RESP_DEPTH+1) | Response length, taken on post |
| resp_post_i | input | 1 | Marks the response as ready for read-back |

## Verification
The hardest condition to reach is the full request buffer. The host has to walk through REQ_DEPTH accepted write steps, each paced by the busy window, before a 0x42 or 0x43 can be turned away for lack of room. The bench drives one first-byte opcode and then 31 middle-byte opcodes. It checks that the room flag drops exactly at the 32nd byte, then sends the last-byte opcode and expects the error code. The other hard case is a host write that lands inside the busy window. The bench reaches it by writing the control register a cycle after setting busy and then checking which opcode took effect.

// File: rtl/hr_pkg.sv
package hr_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_WRITE, PH_WAIT, PH_READ} phase_e;

  localparam logic [7:0] OP_GET      = 8'h40;
  localparam logic [7:0] OP_WR_FIRST = 8'h41;
  localparam logic [7:0] OP_WR_MID   = 8'h42;
  localparam logic [7:0] OP_WR_LAST  = 8'h43;
  localparam logic [7:0] OP_RD_FIRST = 8'h44;
  localparam logic [7:0] OP_RD_MID   = 8'h45;
  localparam logic [7:0] OP_RD_LAST  = 8'h46;

  localparam logic [7:0] ST_READY   = 8'hC0;
  localparam logic [7:0] ST_RD_LAST = 8'hC6;

  localparam int FLAG_BUSY  = 0;
  localparam int FLAG_ATTN  = 3;
  localparam int FLAG_TXRDY = 6;
  localparam int FLAG_RXRDY = 7;

  localparam logic [1:0] A_DATA  = 2'd0;
  localparam logic [1:0] A_CTRL  = 2'd1;
  localparam logic [1:0] A_FLAGS = 2'd2;
endpackage

// File: rtl/hr_busy_ctl.sv
module hr_busy_ctl #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(BUSY_CYCLES);
    end else if (done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/hr_req_buf.sv
module hr_req_buf #(
  parameter int DEPTH = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       wr_i,
  input  logic [7:0]                 wdata_i,
  input  logic [$clog2(DEPTH)-1:0]   raddr_i,
  output logic [7:0]                 rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o,
  output logic                       full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] waddr;

  assign waddr   = clr_i ? '0 : cnt_q[AW-1:0];
  assign rdata_o = mem_q[raddr_i];
  assign cnt_o   = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else begin
      if (wr_i) mem_q[waddr] <= wdata_i;
      if (clr_i)     cnt_q <= CW'(wr_i);
      else if (wr_i) cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/hr_resp_buf.sv
module hr_resp_buf #(
  parameter int DEPTH = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [$clog2(DEPTH)-1:0]   waddr_i,
  input  logic [7:0]                 wdata_i,
  input  logic                       post_i,
  input  logic [$clog2(DEPTH+1)-1:0] len_i,
  input  logic                       clr_i,
  input  logic [$clog2(DEPTH)-1:0]   raddr_i,
  output logic [7:0]                 rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] len_o,
  output logic                       rdy_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] len_q;
  logic          rdy_q;

  assign rdata_o = mem_q[raddr_i];
  assign len_o   = len_q;
  assign rdy_o   = rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      rdy_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
      if (clr_i) begin
        rdy_q <= 1'b0;
      end else if (post_i) begin
        rdy_q <= 1'b1;
        len_q <= len_i;
      end
    end
  end
endmodule

// File: rtl/hr_seq.sv
module hr_seq
  import hr_pkg::*;
#(
  parameter int         RESP_DEPTH = 32,
  parameter logic [7:0] ERR_CODE   = 8'h81
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            fire_i,
  input  logic [7:0]                      op_i,
  input  logic                            req_full_i,
  input  logic                            resp_rdy_i,
  input  logic [$clog2(RESP_DEPTH+1)-1:0] resp_len_i,
  input  logic [7:0]                      resp_byte_i,
  output logic [$clog2(RESP_DEPTH)-1:0]   rd_idx_o,
  output logic                            req_clr_o,
  output logic                            req_wr_o,
  output logic                            resp_clr_o,
  output phase_e                          phase_o,
  output logic [7:0]                      status_o,
  output logic [7:0]                      dout_o
);
  localparam int AW = $clog2(RESP_DEPTH);
  localparam int CW = $clog2(RESP_DEPTH + 1);

  phase_e        phase_q, nxt_phase;
  logic [AW-1:0] idx_q, nxt_idx;
  logic [7:0]    status_q, dout_q, nxt_status;
  logic          legal, present, req_clr, req_wr, resp_clr;
  logic [CW-1:0] idx_plus;

  assign idx_plus = CW'(idx_q) + CW'(1);

  always_comb begin
    legal     = 1'b0;
    present   = 1'b0;
    req_clr   = 1'b0;
    req_wr    = 1'b0;
    resp_clr  = 1'b0;
    nxt_phase = phase_q;
    nxt_idx   = idx_q;
    case (op_i)
      OP_GET: begin
        legal     = 1'b1;
        nxt_phase = PH_IDLE;
      end
      OP_WR_FIRST: if (phase_q == PH_IDLE) begin
        legal     = 1'b1;
        req_clr   = 1'b1;
        req_wr    = 1'b1;
        resp_clr  = 1'b1;
        nxt_phase = PH_WRITE;
      end
      OP_WR_MID: if (phase_q == PH_WRITE && !req_full_i) begin
        legal  = 1'b1;
        req_wr = 1'b1;
      end
      OP_WR_LAST: if (phase_q == PH_WRITE && !req_full_i) begin
        legal     = 1'b1;
        req_wr    = 1'b1;
        nxt_phase = PH_WAIT;
      end
      OP_RD_FIRST: if (phase_q == PH_WAIT && resp_rdy_i && resp_len_i != '0) begin
        legal     = 1'b1;
        present   = 1'b1;
        nxt_idx   = '0;
        nxt_phase = PH_READ;
      end
      OP_RD_MID: if (phase_q == PH_READ && idx_plus < resp_len_i) begin
        legal   = 1'b1;
        present = 1'b1;
        nxt_idx = idx_q + AW'(1);
      end
      OP_RD_LAST: if (phase_q == PH_READ && idx_plus == resp_len_i) begin
        legal     = 1'b1;
        resp_clr  = 1'b1;
        nxt_phase = PH_IDLE;
      end
      default: ;
    endcase
    if (!legal) nxt_phase = PH_IDLE;

    if (!legal || op_i == OP_GET || op_i == OP_RD_LAST)
      nxt_status = ST_READY;
    else if (op_i == OP_RD_MID && CW'(nxt_idx) + CW'(1) == resp_len_i)
      nxt_status = ST_RD_LAST;
    else
      nxt_status = {5'b11000, op_i[2:0]};
  end

  assign rd_idx_o   = nxt_idx;
  assign req_clr_o  = fire_i && req_clr;
  assign req_wr_o   = fire_i && req_wr;
  assign resp_clr_o = fire_i && resp_clr;
  assign phase_o    = phase_q;
  assign status_o   = status_q;
  assign dout_o     = dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      idx_q    <= '0;
      status_q <= ST_READY;
      dout_q   <= 8'h00;
    end else if (fire_i) begin
      phase_q  <= nxt_phase;
      idx_q    <= nxt_idx;
      status_q <= nxt_status;
      dout_q   <= !legal ? ERR_CODE : (present ? resp_byte_i : 8'h00);
    end
  end
endmodule

// File: rtl/hostmsg_responder.sv
module hostmsg_responder
  import hr_pkg::*;
#(
  parameter int         REQ_DEPTH   = 32,
  parameter int         RESP_DEPTH  = 32,
  parameter int         BUSY_CYCLES = 4,
  parameter logic [7:0] ERR_CODE    = 8'h81
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [1:0]                      host_addr_i,
  input  logic                            host_we_i,
  input  logic [7:0]                      host_wdata_i,
  output logic [7:0]                      host_rdata_o,
  input  logic                            attn_i,
  input  logic [$clog2(REQ_DEPTH)-1:0]    req_raddr_i,
  output logic [7:0]                      req_rdata_o,
  output logic [$clog2(REQ_DEPTH+1)-1:0]  req_len_o,
  output logic                            req_done_o,
  input  logic                            resp_we_i,
  input  logic [$clog2(RESP_DEPTH)-1:0]   resp_waddr_i,
  input  logic [7:0]                      resp_wdata_i,
  input  logic [$clog2(RESP_DEPTH+1)-1:0] resp_len_i,
  input  logic                            resp_post_i
);
  localparam int RAW = $clog2(RESP_DEPTH);
  localparam int RCW = $clog2(RESP_DEPTH + 1);

  logic [7:0]     ctrl_q, din_q;
  logic           busy_w, fire_w, start_w;
  logic           req_full_w, req_clr_w, req_wr_w;
  logic           resp_clr_w, resp_rdy_w;
  logic [RCW-1:0] resp_len_w;
  logic [RAW-1:0] rd_idx_w;
  logic [7:0]     resp_byte_w, status_w, dout_w, flags_w;
  phase_e         phase_w;
  logic           txrdy_w, rxrdy_w;

  assign start_w = host_we_i && !busy_w && host_addr_i == A_FLAGS && host_wdata_i[FLAG_BUSY];

  // Host data/control latches are frozen while a step is in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 8'h00;
      din_q  <= 8'h00;
    end else if (host_we_i && !busy_w) begin
      if (host_addr_i == A_DATA) din_q  <= host_wdata_i;
      if (host_addr_i == A_CTRL) ctrl_q <= host_wdata_i;
    end
  end

  hr_busy_ctl #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .busy_o  (busy_w),
    .done_o  (fire_w)
  );

  hr_req_buf #(.DEPTH(REQ_DEPTH)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (req_clr_w),
    .wr_i    (req_wr_w),
    .wdata_i (din_q),
    .raddr_i (req_raddr_i),
    .rdata_o (req_rdata_o),
    .cnt_o   (req_len_o),
    .full_o  (req_full_w)
  );

  hr_resp_buf #(.DEPTH(RESP_DEPTH)) u_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (resp_we_i),
    .waddr_i (resp_waddr_i),
    .wdata_i (resp_wdata_i),
    .post_i  (resp_post_i),
    .len_i   (resp_len_i),
    .clr_i   (resp_clr_w),
    .raddr_i (rd_idx_w),
    .rdata_o (resp_byte_w),
    .len_o   (resp_len_w),
    .rdy_o   (resp_rdy_w)
  );

  hr_seq #(.RESP_DEPTH(RESP_DEPTH), .ERR_CODE(ERR_CODE)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire_w),
    .op_i        (ctrl_q),
    .req_full_i  (req_full_w),
    .resp_rdy_i  (resp_rdy_w),
    .resp_len_i  (resp_len_w),
    .resp_byte_i (resp_byte_w),
    .rd_idx_o    (rd_idx_w),
    .req_clr_o   (req_clr_w),
    .req_wr_o    (req_wr_w),
    .resp_clr_o  (resp_clr_w),
    .phase_o     (phase_w),
    .status_o    (status_w),
    .dout_o      (dout_w)
  );

  assign txrdy_w = (phase_w == PH_IDLE) || (phase_w == PH_WRITE && !req_full_w);
  assign rxrdy_w = (phase_w == PH_WAIT && resp_rdy_w) || (phase_w == PH_READ);

  always_comb begin
    flags_w             = 8'h00;
    flags_w[FLAG_BUSY]  = busy_w;
    flags_w[FLAG_ATTN]  = attn_i;
    flags_w[FLAG_TXRDY] = txrdy_w;
    flags_w[FLAG_RXRDY] = rxrdy_w;
  end

  assign req_done_o = (phase_w == PH_WAIT);

  always_comb begin
    case (host_addr_i)
      A_DATA:  host_rdata_o = dout_w;
      A_CTRL:  host_rdata_o = status_w;
      A_FLAGS: host_rdata_o = flags_w;
      default: host_rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/hostmsg_responder_chk.sv
module hostmsg_responder_chk #(
  parameter int BUSY_CYCLES = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic [7:0] status_i,
  input logic [7:0] dout_i,
  input logic [7:0] flags_i
);
  int unsigned busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt_q <= 0;
    else if (busy_i) busy_cnt_q <= busy_cnt_q + 1;
    else             busy_cnt_q <= 0;
  end

  p_busy_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> busy_cnt_q == BUSY_CYCLES);

  p_status_on_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_i) |-> $fell(busy_i));

  p_status_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i >= 8'hC0 && status_i <= 8'hC6);

  p_wr_end_ok_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 8'hC3) |-> dout_i == 8'h00);

  p_rdy_exclusive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flags_i[7] && flags_i[6]));

  p_last_rx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 8'hC6) |-> flags_i[7]);

  p_flags_not_ones_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_i != 8'hFF);
endmodule

bind hostmsg_responder hostmsg_responder_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_i   (busy_w),
  .status_i (status_w),
  .dout_i   (dout_w),
  .flags_i  (flags_w)
);

// File: tb/hostmsg_responder_tb.sv
module hostmsg_responder_tb;
  localparam int BUSY = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic       host_we = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       attn = 1'b0;
  logic [4:0] req_raddr = '0;
  logic [7:0] req_rdata;
  logic [5:0] req_len;
  logic       req_done;
  logic       resp_we = 1'b0;
  logic [4:0] resp_waddr = '0;
  logic [7:0] resp_wdata = 8'h00;
  logic [5:0] resp_len = '0;
  logic       resp_post = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hostmsg_responder #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_addr_i(host_addr), .host_we_i(host_we), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata), .attn_i(attn),
    .req_raddr_i(req_raddr), .req_rdata_o(req_rdata), .req_len_o(req_len),
    .req_done_o(req_done),
    .resp_we_i(resp_we), .resp_waddr_i(resp_waddr), .resp_wdata_i(resp_wdata),
    .resp_len_i(resp_len), .resp_post_i(resp_post)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic issue(input logic [7:0] op, input logic [7:0] b);
    host_wr(2'd0, b);
    host_wr(2'd1, op);
    host_wr(2'd2, 8'h01);
    repeat (BUSY) @(negedge clk);
  endtask

  task automatic expect_step(input string tag, input logic [7:0] st, input logic [7:0] dt);
    logic [7:0] v;
    rd(2'd1, v); chk({tag, " status"}, v, st);
    rd(2'd0, v); chk({tag, " data"}, v, dt);
  endtask

  task automatic load_resp(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      resp_we = 1'b1; resp_waddr = 5'(i); resp_wdata = base + 8'(i);
    end
    @(negedge clk);
    resp_we = 1'b0; resp_post = 1'b1; resp_len = 6'(n);
    @(negedge clk);
    resp_post = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    expect_step("R1 reset", 8'hC0, 8'h00);
    rd(2'd2, v); chk("R1 reset flags", v, 8'h40);
  endtask

  task automatic t_busy;
    logic [7:0] v;
    host_wr(2'd0, 8'h5A);
    host_wr(2'd1, 8'h41);
    host_wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R2 busy set", v & 8'h01, 8'h01);
    rd(2'd1, v); chk("R2 status held while busy", v, 8'hC0);
    host_wr(2'd1, 8'h46);
    repeat (BUSY - 3) @(negedge clk);
    rd(2'd2, v); chk("R2 busy last cycle", v & 8'h01, 8'h01);
    @(negedge clk);
    rd(2'd2, v); chk("R2 busy cleared", v & 8'h01, 8'h00);
    expect_step("R2 write ignored during busy", 8'hC1, 8'h00);
    chk("R4 first byte count", 8'(req_len), 8'd1);
    req_raddr = 5'd0; #1;
    chk("R4 first byte value", req_rdata, 8'h5A);
    issue(8'h40, 8'h00);
    expect_step("R3 get status", 8'hC0, 8'h00);
    rd(2'd2, v); chk("R3 back to idle flags", v, 8'h40);
  endtask

  task automatic t_xfer;
    logic [7:0] v;
    issue(8'h41, 8'h11); expect_step("R4 wr first", 8'hC1, 8'h00);
    issue(8'h42, 8'h22); expect_step("R4 wr mid", 8'hC2, 8'h00);
    issue(8'h43, 8'h33); expect_step("R5 wr last", 8'hC3, 8'h00);
    chk("R5 req_done", 8'(req_done), 8'd1);
    chk("R4 req_len", 8'(req_len), 8'd3);
    for (int i = 0; i < 3; i++) begin
      req_raddr = 5'(i); #1;
      chk("R4 req byte", req_rdata, 8'h11 * 8'(i + 1));
    end
    rd(2'd2, v); chk("R7 no rx before post", v, 8'h00);
    load_resp(3, 8'hA0);
    rd(2'd2, v); chk("R7 rx after post", v, 8'h80);
    issue(8'h44, 8'h00); expect_step("R8 rd first", 8'hC4, 8'hA0);
    issue(8'h45, 8'h00); expect_step("R8 rd mid", 8'hC5, 8'hA1);
    rd(2'd2, v); chk("R7 rx during read", v, 8'h80);
    issue(8'h45, 8'h00); expect_step("R8 rd last byte", 8'hC6, 8'hA2);
    issue(8'h46, 8'h00); expect_step("R9 rd end", 8'hC0, 8'h00);
    rd(2'd2, v); chk("R9 flags after end", v, 8'h40);
    chk("R5 req_done cleared", 8'(req_done), 8'd0);
  endtask

  task automatic t_rd_errors;
    issue(8'h41, 8'h01);
    issue(8'h43, 8'h02);
    issue(8'h44, 8'h00); expect_step("R7 rd before post", 8'hC0, 8'h81);
    issue(8'h41, 8'h03);
    issue(8'h43, 8'h04);
    load_resp(3, 8'hB0);
    issue(8'h44, 8'h00); expect_step("R8 rd first again", 8'hC4, 8'hB0);
    issue(8'h46, 8'h00); expect_step("R9 early rd end", 8'hC0, 8'h81);
    issue(8'h41, 8'h05);
    issue(8'h43, 8'h06);
    load_resp(1, 8'hD0);
    issue(8'h44, 8'h00); expect_step("R8 single byte", 8'hC4, 8'hD0);
    issue(8'h45, 8'h00); expect_step("R8 rd mid past end", 8'hC0, 8'h81);
  endtask

  task automatic t_seq_errors;
    issue(8'h45, 8'h00); expect_step("R10 rd mid in idle", 8'hC0, 8'h81);
    issue(8'h4F, 8'h00); expect_step("R10 unknown op", 8'hC0, 8'h81);
    issue(8'h43, 8'h00); expect_step("R10 wr last in idle", 8'hC0, 8'h81);
    issue(8'h41, 8'h77); expect_step("R10 recovery wr first", 8'hC1, 8'h00);
    issue(8'h41, 8'h78); expect_step("R10 wr first twice", 8'hC0, 8'h81);
  endtask

  task automatic t_full;
    logic [7:0] v;
    issue(8'h41, 8'hE0);
    for (int i = 1; i < 32; i++) begin
      if (i == 31) begin
        rd(2'd2, v); chk("R6 room at 31 bytes", v & 8'h40, 8'h40);
      end
      issue(8'h42, 8'(i));
    end
    rd(2'd2, v); chk("R6 no room when full", v & 8'h40, 8'h00);
    chk("R6 full count", 8'(req_len), 8'd32);
    req_raddr = 5'd31; #1;
    chk("R6 last stored byte", req_rdata, 8'd31);
    issue(8'h43, 8'hFF); expect_step("R6 wr last into full", 8'hC0, 8'h81);
    chk("R6 count unchanged", 8'(req_len), 8'd32);
  endtask

  task automatic t_attn;
    logic [7:0] v;
    attn = 1'b1; #1;
    rd(2'd2, v); chk("R11 attention flag", v, 8'h48);
    rd(2'd3, v); chk("R11 unused address", v, 8'h00);
    attn = 1'b0; #1;
    rd(2'd2, v); chk("R11 attention cleared", v, 8'h40);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_busy();
    t_xfer();
    t_rd_errors();
    t_seq_errors();
    issue(8'h40, 8'h00);
    t_full();
    t_attn();
    report();
  end
endmodule